// File: doc/BRIEF.md
# Voice Superframe Serializer

The block builds a voice superframe of four frames for a narrowband digital radio link and sends it as one serial bit stream, one bit per clock. Each frame has three fields in a fixed order. The header comes first. Frames 0 and 2 carry a fixed synchronisation word in the header, and frames 1 and 3 carry the colour code. The control-channel word follows the header, and the vocoder payload comes last. Header and control bits go out most significant bit first, so each byte leaves MSB first. In the payload, vocoder bit D0 leaves first and the highest-numbered bit leaves last.

A start pulse, accepted only while the block is idle, begins a superframe. The colour code is captured with the start pulse. The control word and the payload buffer are captured at each frame boundary. At those edges the block raises a one-cycle payload ready, and a transfer takes place when payload valid is high in the same cycle. If payload valid is low at a boundary, the frame's payload goes out as zeros and an underrun flag is set. After the last bit of frame 3 the block pulses superframe-done and returns to idle.

Top module: `sf_voice_serializer`

## Requirements
- R1: A synchronous active-high reset leaves the block idle. After reset, bit_vld_o, sf_done_o, underrun_o and pay_ready_o are low and frame_idx_o is 0.
- R2: A start pulse while idle makes bit_vld_o high from the next cycle for exactly 4 x FRAME_BITS consecutive cycles, where FRAME_BITS = HDR_BITS + CTL_BITS + PAY_BITS (default 288, which is 36 bytes).
- R3: The first HDR_BITS bits of frames 0 and 2 are SYNC_PAT, and those of frames 1 and 3 are the colour code captured with the start pulse. Both are sent bit HDR_BITS-1 first.
- R4: The next CTL_BITS bits of each frame are the control word captured at that frame's boundary, sent bit CTL_BITS-1 first.
- R5: The last PAY_BITS bits of each frame are the payload captured at that frame's boundary, sent bit 0 (D0) first in ascending order.
- R6: pay_ready_o is high only in the cycle whose closing edge begins a frame: the start cycle while idle, and the last-bit cycle of frames 0 to 2. The control word and the payload are sampled only on that edge, so changes at other times have no effect on the stream.
- R7: If pay_valid_i is low when a frame begins, that frame's payload field is all zeros. underrun_o is then high from the next cycle until the next accepted start.
- R8: sf_done_o is a one-cycle pulse in the cycle right after the last bit of frame 3, and bit_vld_o is low in that cycle. A start in that cycle is accepted.
- R9: A start pulse while a superframe is in progress is ignored.
- R10: frame_idx_o equals the index (0 to 3) of the frame whose bits are on bit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a superframe (honoured while idle) |
| colour_i | input | HDR_BITS | Colour code, captured at start |
| ctl_i | input | CTL_BITS | Control-channel word, captured at each frame boundary |
| pay_data_i | input | PAY_BITS | Vocoder payload, bit k is Dk |
| pay_valid_i | input | 1 | Payload available |
| pay_ready_o | output | 1 | Frame boundary; payload taken when valid |
| bit_o | output | 1 | Serial data bit |
| bit_vld_o | output | 1 | bit_o carries a superframe bit |
| frame_idx_o | output | FW (2) | Index of the current frame |
| sf_done_o | output | 1 | Superframe finished (one-cycle pulse) |
| underrun_o | output | 1 | A frame of this superframe had no payload |

## Verification
The assertions assume the inputs are synchronous to clk and that the payload and control inputs hold meaningful values on the boundary edges marked by pay_ready_o. Apart from that, any input may change in any cycle. The stimulus loads each frame's values in the negedge just before a boundary edge. It then overwrites the colour, control, payload and valid inputs with random values right after that edge, so any sampling outside a boundary would corrupt the stream. The seeded random draws choose the payload-valid pattern, the gaps between superframes, and the mid-superframe start pulses. Directed cases cover all-underrun, back-to-back starts in the done cycle, and reset.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [1:0] {FLD_HDR, FLD_CTL, FLD_PAY} fld_e;

  // Which field a bit position within a frame belongs to.
  function automatic fld_e field_of(int unsigned pos, int unsigned hb, int unsigned cb);
    if (pos < hb)           return FLD_HDR;
    else if (pos < hb + cb) return FLD_CTL;
    else                    return FLD_PAY;
  endfunction

  // Vector index for offset 'off' in a field sent most significant bit first.
  function automatic int unsigned msb_first_idx(int unsigned off, int unsigned width);
    return width - 1 - off;
  endfunction

  // Even frames carry the sync word and odd frames the colour code.
  function automatic logic hdr_uses_sync(int unsigned fidx);
    return (fidx % 2) == 0;
  endfunction

endpackage

// File: rtl/sfs_sequencer.sv
module sfs_sequencer #(
  parameter int FRAME_BITS = 288,
  parameter int NFRAMES    = 4,
  localparam int PW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic [PW-1:0] pos_o,
  output logic [FW-1:0] fidx_o,
  output logic          first_o,
  output logic          load_o,
  output logic          done_o
);
  localparam logic [PW-1:0] LAST_POS  = PW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] LAST_FIDX = FW'(NFRAMES - 1);

  logic last_bit, last_frame, end_sf;

  assign last_bit   = busy_o && (pos_o == LAST_POS);
  assign last_frame = (fidx_o == LAST_FIDX);
  assign end_sf     = last_bit && last_frame;
  assign first_o    = !busy_o && start_i;
  assign load_o     = first_o || (last_bit && !last_frame);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      pos_o  <= '0;
      fidx_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= end_sf;
      if (first_o) begin
        busy_o <= 1'b1;
        pos_o  <= '0;
        fidx_o <= '0;
      end else if (busy_o) begin
        if (last_bit) begin
          pos_o <= '0;
          if (last_frame) begin
            busy_o <= 1'b0;
            fidx_o <= '0;
          end else begin
            fidx_o <= fidx_o + 1'b1;
          end
        end else begin
          pos_o <= pos_o + 1'b1;
        end
      end
    end
  end

  // R2
  frame_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && pos_o == LAST_POS && fidx_o != LAST_FIDX)
      |=> (busy_o && pos_o == '0 && fidx_o == $past(fidx_o) + 1'b1));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && pos_o != LAST_POS)
      |=> (busy_o && pos_o == $past(pos_o) + 1'b1 && fidx_o == $past(fidx_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o) && $past(fidx_o) == LAST_FIDX));

endmodule

// File: rtl/sfs_latch.sv
module sfs_latch #(
  parameter int HDR_BITS = 24,
  parameter int CTL_BITS = 48,
  parameter int PAY_BITS = 216
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                first_i,
  input  logic                load_i,
  input  logic [HDR_BITS-1:0] colour_i,
  input  logic [CTL_BITS-1:0] ctl_i,
  input  logic [PAY_BITS-1:0] pay_data_i,
  input  logic                pay_valid_i,
  output logic [HDR_BITS-1:0] colour_q,
  output logic [CTL_BITS-1:0] ctl_q,
  output logic [PAY_BITS-1:0] pay_q,
  output logic                underrun_o
);
  logic missing;
  assign missing = load_i && !pay_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      colour_q   <= '0;
      ctl_q      <= '0;
      pay_q      <= '0;
      underrun_o <= 1'b0;
    end else begin
      if (first_i) colour_q <= colour_i;
      if (load_i) begin
        ctl_q <= ctl_i;
        pay_q <= pay_valid_i ? pay_data_i : '0;
      end
      if (first_i)      underrun_o <= missing;
      else if (missing) underrun_o <= 1'b1;
    end
  end

  // R6
  hold_between_loads_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(ctl_q) && $stable(pay_q)));

  // R7
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !pay_valid_i) |=> (pay_q == '0 && underrun_o));

endmodule

// File: rtl/sfs_bitmux.sv
module sfs_bitmux
  import sfs_pkg::*;
#(
  parameter int HDR_BITS = 24,
  parameter int CTL_BITS = 48,
  parameter int PAY_BITS = 216,
  parameter logic [HDR_BITS-1:0] SYNC_PAT = '0,
  parameter int PW = 9,
  parameter int FW = 2
) (
  input  logic                busy_i,
  input  logic [PW-1:0]       pos_i,
  input  logic [FW-1:0]       fidx_i,
  input  logic [HDR_BITS-1:0] colour_q,
  input  logic [CTL_BITS-1:0] ctl_q,
  input  logic [PAY_BITS-1:0] pay_q,
  output logic                bit_o
);
  localparam int HIW = (HDR_BITS > 1) ? $clog2(HDR_BITS) : 1;
  localparam int CIW = (CTL_BITS > 1) ? $clog2(CTL_BITS) : 1;
  localparam int PIW = (PAY_BITS > 1) ? $clog2(PAY_BITS) : 1;

  logic [HDR_BITS-1:0] hdr_word;
  logic [HIW-1:0]      hidx;
  logic [CIW-1:0]      cidx;
  logic [PIW-1:0]      pidx;
  int unsigned         p;
  fld_e                fld;
  logic                sel_bit;

  assign hdr_word = hdr_uses_sync(32'(fidx_i)) ? SYNC_PAT : colour_q;

  always_comb begin
    p       = 32'(pos_i);
    fld     = field_of(p, HDR_BITS, CTL_BITS);
    hidx    = '0;
    cidx    = '0;
    pidx    = '0;
    sel_bit = 1'b0;
    case (fld)
      FLD_HDR: begin
        hidx    = HIW'(msb_first_idx(p, HDR_BITS));
        sel_bit = hdr_word[hidx];
      end
      FLD_CTL: begin
        cidx    = CIW'(msb_first_idx(p - HDR_BITS, CTL_BITS));
        sel_bit = ctl_q[cidx];
      end
      default: begin
        pidx    = PIW'(p - HDR_BITS - CTL_BITS);
        sel_bit = pay_q[pidx];
      end
    endcase
  end

  assign bit_o = busy_i & sel_bit;

endmodule

// File: rtl/sf_voice_serializer.sv
module sf_voice_serializer #(
  parameter int HDR_BITS = 24,
  parameter int CTL_BITS = 48,
  parameter int PAY_BITS = 216,
  parameter int NFRAMES  = 4,
  parameter logic [HDR_BITS-1:0] SYNC_PAT = 24'hA7_1E_5B,
  localparam int FRAME_BITS = HDR_BITS + CTL_BITS + PAY_BITS,
  localparam int PW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1,
  localparam int FW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [HDR_BITS-1:0] colour_i,
  input  logic [CTL_BITS-1:0] ctl_i,
  input  logic [PAY_BITS-1:0] pay_data_i,
  input  logic                pay_valid_i,
  output logic                pay_ready_o,
  output logic                bit_o,
  output logic                bit_vld_o,
  output logic [FW-1:0]       frame_idx_o,
  output logic                sf_done_o,
  output logic                underrun_o
);
  logic                busy, first, load;
  logic [PW-1:0]       pos;
  logic [HDR_BITS-1:0] colour_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic [PAY_BITS-1:0] pay_q;

  sfs_sequencer #(.FRAME_BITS(FRAME_BITS), .NFRAMES(NFRAMES)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy_o(busy), .pos_o(pos), .fidx_o(frame_idx_o),
    .first_o(first), .load_o(load), .done_o(sf_done_o)
  );

  sfs_latch #(.HDR_BITS(HDR_BITS), .CTL_BITS(CTL_BITS), .PAY_BITS(PAY_BITS)) u_latch (
    .clk(clk), .rst(rst), .first_i(first), .load_i(load),
    .colour_i(colour_i), .ctl_i(ctl_i), .pay_data_i(pay_data_i),
    .pay_valid_i(pay_valid_i), .colour_q(colour_q), .ctl_q(ctl_q),
    .pay_q(pay_q), .underrun_o(underrun_o)
  );

  sfs_bitmux #(.HDR_BITS(HDR_BITS), .CTL_BITS(CTL_BITS), .PAY_BITS(PAY_BITS),
               .SYNC_PAT(SYNC_PAT), .PW(PW), .FW(FW)) u_mux (
    .busy_i(busy), .pos_i(pos), .fidx_i(frame_idx_o),
    .colour_q(colour_q), .ctl_q(ctl_q), .pay_q(pay_q), .bit_o(bit_o)
  );

  assign pay_ready_o = load;
  assign bit_vld_o   = busy;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!bit_vld_o && !sf_done_o && !underrun_o && frame_idx_o == '0));

endmodule

// File: tb/sf_voice_serializer_bench.sv
module sf_voice_serializer_bench;
  localparam int HB = 24, CB = 48, PB = 216, NF = 4;
  localparam int FB = HB + CB + PB;
  localparam logic [HB-1:0] SYNC = 24'hA7_1E_5B;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, pay_valid_i = 1'b0;
  logic [HB-1:0] colour_i = '0;
  logic [CB-1:0] ctl_i = '0;
  logic [PB-1:0] pay_data_i = '0;
  logic pay_ready_o, bit_o, bit_vld_o, sf_done_o, underrun_o;
  logic [1:0] frame_idx_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sf_voice_serializer #(.HDR_BITS(HB), .CTL_BITS(CB), .PAY_BITS(PB),
                        .NFRAMES(NF), .SYNC_PAT(SYNC)) u_sf_voice_serializer (
    .clk(clk), .rst(rst), .start_i(start_i), .colour_i(colour_i), .ctl_i(ctl_i),
    .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .frame_idx_o(frame_idx_o),
    .sf_done_o(sf_done_o), .underrun_o(underrun_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PB-1:0] rand_pay();
    logic [PB-1:0] v;
    for (int k = 0; k < PB; k++) v[k] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  function automatic logic [CB-1:0] rand_ctl();
    return {$urandom(), $urandom()};
  endfunction

  // Expected bit at position b of frame f, restated from the field rules.
  function automatic logic exp_bit(int f, int b, logic [HB-1:0] cc, logic [CB-1:0] cw,
                                   logic [PB-1:0] pw, bit pv);
    logic [HB-1:0] h;
    h = (f % 2 == 0) ? SYNC : cc;
    if (b < HB)      return h[HB-1-b];
    if (b < HB + CB) return cw[CB-1-(b-HB)];
    return pv ? pw[b-HB-CB] : 1'b0;
  endfunction

  task automatic scramble();
    colour_i    = HB'($urandom());
    ctl_i       = rand_ctl();
    pay_data_i  = rand_pay();
    pay_valid_i = 1'($urandom_range(0, 1));
  endtask

  // Runs one superframe; entered and left at a negedge (the done cycle).
  task automatic run_sf(input bit [3:0] pv, input bit poke);
    logic [HB-1:0] cc;
    logic [CB-1:0] cw[NF];
    logic [PB-1:0] pw[NF];
    logic got[NF][FB];
    int vld_bad = 0, idx_bad = 0, rdy_bad = 0;
    cc = HB'($urandom());
    for (int f = 0; f < NF; f++) begin cw[f] = rand_ctl(); pw[f] = rand_pay(); end
    colour_i = cc; ctl_i = cw[0]; pay_data_i = pw[0]; pay_valid_i = pv[0];
    start_i = 1'b1;
    #1;
    check(pay_ready_o == 1'b1, "R6", "ready at start", pay_ready_o, 1);
    @(posedge clk); #2;
    start_i = 1'b0;
    scramble();
    for (int f = 0; f < NF; f++) begin
      for (int b = 0; b < FB; b++) begin
        @(negedge clk);
        if (b == 0 && f > 0) scramble();
        got[f][b] = bit_o;
        if (bit_vld_o !== 1'b1) vld_bad++;
        if (frame_idx_o !== 2'(f)) idx_bad++;
        if (pay_ready_o !== ((b == FB-1) && (f < NF-1))) rdy_bad++;
        if (poke && f == 1 && b == 100) start_i = 1'b1;   // R9 stimulus
        if (b == 101) start_i = 1'b0;
        if (b == FB-1 && f < NF-1) begin
          ctl_i = cw[f+1]; pay_data_i = pw[f+1]; pay_valid_i = pv[f+1];
        end
      end
    end
    @(negedge clk);
    check(sf_done_o == 1'b1, "R8", "done after last bit", sf_done_o, 1);
    check(bit_vld_o == 1'b0, "R8", "valid low in done cycle", bit_vld_o, 0);
    check(underrun_o == ~&pv, "R7", "underrun flag", underrun_o, ~&pv);
    check(vld_bad == 0, poke ? "R9" : "R2", "valid gaps in superframe", vld_bad, 0);
    check(idx_bad == 0, "R10", "frame index mismatches", idx_bad, 0);
    check(rdy_bad == 0, "R6", "ready at non-boundary cycles", rdy_bad, 0);
    for (int f = 0; f < NF; f++) begin
      int hb = 0, cbad = 0, pbad = 0;
      for (int b = 0; b < FB; b++) begin
        if (got[f][b] !== exp_bit(f, b, cc, cw[f], pw[f], pv[f])) begin
          if (b < HB) hb++; else if (b < HB + CB) cbad++; else pbad++;
        end
      end
      check(hb == 0, "R3", $sformatf("header bit errors frame %0d", f), hb, 0);
      check(cbad == 0, "R4", $sformatf("control bit errors frame %0d", f), cbad, 0);
      check(pbad == 0, pv[f] ? "R5" : "R7",
            $sformatf("payload bit errors frame %0d", f), pbad, 0);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(sf_done_o == 1'b0 && bit_vld_o == 1'b0, "R8", "idle after done",
            {sf_done_o, bit_vld_o}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(bit_vld_o == 1'b0 && sf_done_o == 1'b0 && underrun_o == 1'b0, "R1",
          "flags after reset", {bit_vld_o, sf_done_o, underrun_o}, 0);
    check(frame_idx_o == 2'd0 && pay_ready_o == 1'b0, "R1", "index/ready after reset",
          {frame_idx_o, pay_ready_o}, 0);
    @(negedge clk);
    run_sf(4'b1111, 1'b0);
    idle_gap(3);
    run_sf(4'b0000, 1'b0);              // directed: every frame underruns
    run_sf(4'b1111, 1'b1);              // back-to-back start, mid-frame start poke
    idle_gap(1);
    run_sf(4'b1010, 1'b0);
    for (int s = 0; s < 4; s++) begin
      run_sf(4'($urandom()), 1'($urandom_range(0, 1)));
      idle_gap($urandom_range(1, 4));
    end
    // R1: reset in the middle of a superframe
    start_i = 1'b1; pay_valid_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(bit_vld_o == 1'b0 && underrun_o == 1'b0 && frame_idx_o == 2'd0, "R1",
          "reset mid-superframe", {bit_vld_o, underrun_o, frame_idx_o}, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule